// File: doc/BRIEF.md
# POST Code Byte Reassembler

This block sits behind a capture FIFO that collects writes to the POST-code port. Each FIFO entry carries one data byte and a byte-lane index. The block drains the FIFO and rebuilds multi-byte codes: each byte is OR-merged into an accumulator at bit position eight times its lane. A code is finished in either of two cases. The first is an entry on lane zero arriving while a partial code is held. The second is the end of a burst, which is any cycle in which nothing is popped. Finished codes leave on a registered valid/data interface, together with a mask of the lanes that contributed.

Bursts are bounded by the depth of the drain window. After that many back-to-back pops the block pauses for one cycle, and that pause closes the burst just as an empty FIFO would. The block also keeps two flags for the FIFO. The first is a sticky overflow flag with a one-cycle error pulse per overflow event. The second is a host-write-pending flag that may only be cleared once the drain is idle.

Top module: `post_code_reasm`

## Requirements
- R1: After reset `code_vld`, `ovf_sticky`, `ovf_err` and `hwr_pend` are 0, and `fifo_pop` follows only `fifo_nempty`.
- R2: `fifo_pop` is high in the same cycle that `fifo_nempty` is high, unless the burst window is full (R6). A popped byte is OR-ed into bits [8*lane+7 : 8*lane] of the accumulator and sets mask bit `lane`.
- R3: A popped entry with lane 0, arriving while a partial code is held, emits the held code and mask. The new byte then starts a fresh code. `code_vld` is high for the one cycle after that clock edge.
- R4: A cycle without a pop emits the held partial code, if any, in the cycle after the edge, and clears the accumulator.
- R5: Two entries on the same lane within one code are OR-combined, not replaced.
- R6: After `DRAIN_DEPTH` (16) consecutive pops, `fifo_pop` stays low for one cycle even if the FIFO is not empty. That cycle ends the burst as in R4.
- R7: `ovf_sticky` is set by `ovf_evt` and cleared by `ovf_clr`. Set has priority when both occur together.
- R8: `ovf_err` is high for exactly the one cycle after each cycle with `ovf_evt` high.
- R9: `hwr_pend` is set by `hwr_evt`. `hwr_clr` clears it only when `fifo_nempty` is low and no partial code is held; otherwise `hwr_clr` has no effect. Set has priority.
- R10: A lane-0 entry with no partial code held emits nothing. `code_lanes` is never zero while `code_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_nempty | input | 1 | Capture FIFO holds at least one entry |
| fifo_byte | input | 8 | Data byte of the head entry |
| fifo_lane | input | 2 | Byte-lane index of the head entry |
| fifo_pop | output | 1 | Head entry consumed this cycle |
| ovf_evt | input | 1 | FIFO overflow event |
| ovf_clr | input | 1 | Write-1 clear of the overflow flag |
| hwr_evt | input | 1 | Host write event into the FIFO |
| hwr_clr | input | 1 | Write-1 clear of the write-pending flag |
| code_vld | output | 1 | Finished code present |
| code_val | output | 32 | Reassembled code |
| code_lanes | output | 4 | Lanes that contributed to the code |
| ovf_sticky | output | 1 | Sticky overflow flag |
| ovf_err | output | 1 | One-cycle pulse per overflow event |
| hwr_pend | output | 1 | Host-write-pending flag |

## Verification
`fifo_pop` is combinational, so the bench reads it one time step after driving the head entry, before the clock edge. Every other result is due one edge later. A code closed by a lane-0 pop or by a pop-less cycle, a flag change and the error pulse all become visible in the cycle after the edge that saw their cause. The bench drives inputs at the falling edge, lets one rising edge pass, and compares at the next falling edge against a reference model that has stepped once. The R6 pause is checked on the pop line exactly in the seventeenth cycle of an unbroken run.

// File: rtl/post80_pkg.sv
package post80_pkg;
  localparam int unsigned P80_BYTE_W = 8;
endpackage

// File: rtl/p80_flag.sv
// Sticky flag: set event has priority; clear honoured only when permitted.
module p80_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  input  logic clr_ok,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)                flag <= 1'b0;
    else if (set_evt)          flag <= 1'b1;
    else if (clr_req && clr_ok) flag <= 1'b0;
  end

  // R7 R9: a set event always leaves the flag high
  a_r7_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  // R7 R9: the flag only drops after a permitted clear request
  a_r7_r9_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr_req && clr_ok && !set_evt));
endmodule

// File: rtl/p80_assembler.sv
module p80_assembler
  import post80_pkg::*;
#(
  parameter int unsigned CODE_BYTES  = 4,
  parameter int unsigned DRAIN_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ent_valid,
  input  logic [P80_BYTE_W-1:0]       ent_byte,
  input  logic [$clog2(CODE_BYTES)-1:0] ent_lane,
  output logic                        ent_pop,
  output logic                        code_vld,
  output logic [P80_BYTE_W*CODE_BYTES-1:0] code_val,
  output logic [CODE_BYTES-1:0]       code_lanes,
  output logic                        partial_idle
);
  localparam int unsigned LANE_W = $clog2(CODE_BYTES);
  localparam int unsigned CODE_W = P80_BYTE_W * CODE_BYTES;
  localparam int unsigned CNT_W  = $clog2(DRAIN_DEPTH + 1);

  function automatic logic [CODE_W-1:0] lane_place(input logic [P80_BYTE_W-1:0] b,
                                                   input logic [LANE_W-1:0] l);
    lane_place = CODE_W'(b) << {l, 3'b000};
  endfunction

  function automatic logic [CODE_BYTES-1:0] lane_bit(input logic [LANE_W-1:0] l);
    lane_bit = CODE_BYTES'(1) << l;
  endfunction

  logic [CODE_W-1:0]     acc;
  logic [CODE_BYTES-1:0] mask;
  logic [CNT_W-1:0]      cnt;

  // Named internal events
  logic burst_full, start_new, drain_flush, emit;
  logic [CODE_W-1:0]     base_acc;
  logic [CODE_BYTES-1:0] base_mask;

  always_comb begin
    burst_full   = (cnt == CNT_W'(DRAIN_DEPTH));
    ent_pop      = ent_valid && !burst_full;
    partial_idle = (mask == '0);
    start_new    = ent_pop && (ent_lane == '0) && !partial_idle;
    drain_flush  = !ent_pop && !partial_idle;
    emit         = start_new || drain_flush;
    base_acc     = start_new ? '0 : acc;
    base_mask    = start_new ? '0 : mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      mask       <= '0;
      cnt        <= '0;
      code_vld   <= 1'b0;
      code_val   <= '0;
      code_lanes <= '0;
    end else begin
      code_vld <= emit;
      if (emit) begin
        code_val   <= acc;
        code_lanes <= mask;
      end
      if (ent_pop) begin
        acc  <= base_acc | lane_place(ent_byte, ent_lane);
        mask <= base_mask | lane_bit(ent_lane);
        cnt  <= cnt + 1'b1;
      end else begin
        acc  <= '0;
        mask <= '0;
        cnt  <= '0;
      end
    end
  end

  // R2: never consume from an empty FIFO
  a_r2_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    ent_pop |-> ent_valid);
  // R2: after a pop a partial code is always held
  a_r2_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ent_pop |=> !partial_idle);
  // R3: lane-0 entry over a held code produces an output next cycle
  a_r3_lane0_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_pop && ent_lane == '0 && !partial_idle) |=> code_vld);
  // R4: a pop-less cycle with a held code produces an output next cycle
  a_r4_drain_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (!ent_pop && !partial_idle) |=> (code_vld && partial_idle));
  // R6: a full burst window blocks the pop
  a_r6_burst_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(DRAIN_DEPTH)) |-> !ent_pop);
  // R10: an emitted code always has at least one lane
  a_r10_lanes_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |-> (code_lanes != '0));
endmodule

// File: rtl/post_code_reasm.sv
module post_code_reasm #(
  parameter int unsigned CODE_BYTES  = 4,
  parameter int unsigned DRAIN_DEPTH = 16,
  localparam int unsigned LANE_W = $clog2(CODE_BYTES),
  localparam int unsigned CODE_W = 8 * CODE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_nempty,
  input  logic [7:0]        fifo_byte,
  input  logic [LANE_W-1:0] fifo_lane,
  output logic              fifo_pop,
  input  logic              ovf_evt,
  input  logic              ovf_clr,
  input  logic              hwr_evt,
  input  logic              hwr_clr,
  output logic              code_vld,
  output logic [CODE_W-1:0] code_val,
  output logic [CODE_BYTES-1:0] code_lanes,
  output logic              ovf_sticky,
  output logic              ovf_err,
  output logic              hwr_pend
);
  logic partial_idle;
  logic drain_idle;

  p80_assembler #(.CODE_BYTES(CODE_BYTES), .DRAIN_DEPTH(DRAIN_DEPTH)) u_asm (
    .clk          (clk),
    .rst_n        (rst_n),
    .ent_valid    (fifo_nempty),
    .ent_byte     (fifo_byte),
    .ent_lane     (fifo_lane),
    .ent_pop      (fifo_pop),
    .code_vld     (code_vld),
    .code_val     (code_val),
    .code_lanes   (code_lanes),
    .partial_idle (partial_idle)
  );

  assign drain_idle = !fifo_nempty && partial_idle;

  p80_flag u_ovf (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (ovf_evt),
    .clr_req (ovf_clr),
    .clr_ok  (1'b1),
    .flag    (ovf_sticky)
  );

  p80_flag u_hwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (hwr_evt),
    .clr_req (hwr_clr),
    .clr_ok  (drain_idle),
    .flag    (hwr_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_err <= 1'b0;
    else        ovf_err <= ovf_evt;
  end

  // R8: each error pulse traces back to an overflow event one cycle earlier
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> $past(ovf_evt));
  a_r8_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_err);
  // R9: a clear request while draining leaves the pending flag unchanged
  a_r9_clear_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (hwr_pend && hwr_clr && !drain_idle) |=> hwr_pend);
endmodule

// File: tb/test_post_code_reasm.sv
module test_post_code_reasm;
  localparam int unsigned CB    = 4;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned CW    = 8 * CB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_nempty = 1'b0;
  logic [7:0] fifo_byte = '0;
  logic [1:0] fifo_lane = '0;
  logic ovf_evt = 1'b0, ovf_clr = 1'b0, hwr_evt = 1'b0, hwr_clr = 1'b0;
  logic fifo_pop, code_vld, ovf_sticky, ovf_err, hwr_pend;
  logic [CW-1:0] code_val;
  logic [CB-1:0] code_lanes;

  always #4 clk = ~clk;

  post_code_reasm #(.CODE_BYTES(CB), .DRAIN_DEPTH(DEPTH)) i_post_code_reasm (
    .clk(clk), .rst_n(rst_n), .fifo_nempty(fifo_nempty), .fifo_byte(fifo_byte),
    .fifo_lane(fifo_lane), .fifo_pop(fifo_pop), .ovf_evt(ovf_evt), .ovf_clr(ovf_clr),
    .hwr_evt(hwr_evt), .hwr_clr(hwr_clr), .code_vld(code_vld), .code_val(code_val),
    .code_lanes(code_lanes), .ovf_sticky(ovf_sticky), .ovf_err(ovf_err), .hwr_pend(hwr_pend)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference state
  logic [CW-1:0] m_acc = '0;
  logic [CB-1:0] m_mask = '0;
  int            m_run = 0;
  bit            e_vld = 0;
  logic [CW-1:0] e_code = '0;
  logic [CB-1:0] e_mask = '0;
  string         e_tag = "R10";
  bit            e_ovf = 0, e_err = 0, e_hwr = 0;

  function automatic logic [CW-1:0] bench_place(input logic [7:0] b, input logic [1:0] ln);
    logic [CW-1:0] w;
    w = CW'(b);
    for (int k = 0; k < int'(ln); k++) w = w * 256;
    return w;
  endfunction

  task automatic check(input string tag, input string what, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit ne, input logic [7:0] b, input logic [1:0] ln,
                      input bit oe, input bit oc, input bit he, input bit hc);
    bit pop_e, idle;
    fifo_nempty = ne; fifo_byte = b; fifo_lane = ln;
    ovf_evt = oe; ovf_clr = oc; hwr_evt = he; hwr_clr = hc;
    #1;
    pop_e = ne && (m_run != DEPTH);
    check((ne && m_run == DEPTH) ? "R6" : "R2", "pop", CW'(fifo_pop), CW'(pop_e));
    idle = !ne && (m_mask == 0);
    e_vld = 0; e_tag = "R10";
    if (pop_e) begin
      if (ln == 2'd0 && m_mask != 0) begin
        e_vld = 1; e_code = m_acc; e_mask = m_mask; e_tag = "R3";
        m_acc = '0; m_mask = '0;
      end
      m_acc  = m_acc | bench_place(b, ln);
      m_mask = m_mask | CB'(1 << ln);
      m_run++;
    end else begin
      if (m_mask != 0) begin
        e_vld = 1; e_code = m_acc; e_mask = m_mask;
        e_tag = (m_run == DEPTH) ? "R6" : "R4";
      end
      m_acc = '0; m_mask = '0; m_run = 0;
    end
    if (oe) e_ovf = 1; else if (oc) e_ovf = 0;
    e_err = oe;
    if (he) e_hwr = 1; else if (hc && idle) e_hwr = 0;
    @(negedge clk);
    check(e_tag, "code_vld", CW'(code_vld), CW'(e_vld));
    if (e_vld) begin
      check(e_tag, "code_val", code_val, e_code);
      check(e_tag, "code_lanes", CW'(code_lanes), CW'(e_mask));
    end
    check("R7", "ovf_sticky", CW'(ovf_sticky), CW'(e_ovf));
    check("R8", "ovf_err", CW'(ovf_err), CW'(e_err));
    check("R9", "hwr_pend", CW'(hwr_pend), CW'(e_hwr));
  endtask

  task automatic feed(input logic [7:0] b, input logic [1:0] ln);
    step(1, b, ln, 0, 0, 0, 0);
  endtask

  task automatic idle_cyc();
    step(0, 8'h00, 2'd0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", "code_vld", CW'(code_vld), '0);
    check("R1", "ovf_sticky", CW'(ovf_sticky), '0);
    check("R1", "ovf_err", CW'(ovf_err), '0);
    check("R1", "hwr_pend", CW'(hwr_pend), '0);
    #1 check("R1", "pop idle", CW'(fifo_pop), '0);

    // R2 R10: full four-lane code; first lane-0 entry emits nothing
    feed(8'h11, 2'd0); feed(8'h22, 2'd1); feed(8'h33, 2'd2); feed(8'h44, 2'd3);
    idle_cyc();
    check("R2", "four-lane code", code_val, 32'h4433_2211);
    idle_cyc();

    // R3: lane-0 restart splits codes
    feed(8'hAA, 2'd0); feed(8'hBB, 2'd1); feed(8'hCC, 2'd0);
    check("R3", "first code", code_val, 32'h0000_BBAA);
    idle_cyc();
    check("R4", "tail code", code_val, 32'h0000_00CC);

    // R5: same lane twice ORs
    feed(8'h0F, 2'd1); feed(8'hF0, 2'd1); idle_cyc();
    check("R5", "or merge", code_val, 32'h0000_FF00);
    check("R5", "or mask", CW'(code_lanes), CW'(4'b0010));

    // R6: long burst pauses after DEPTH pops
    for (int i = 0; i < 20; i++) feed(8'(i + 1), 2'(i % 4));
    idle_cyc(); idle_cyc();

    // R7: set wins over clear, then clear alone
    step(0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    // R9: clear while FIFO not empty is ignored; clear when idle works
    step(0, 0, 0, 0, 0, 1, 0);
    step(1, 8'h5A, 2'd2, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 10) < 7, 8'($urandom), 2'($urandom),
           ($urandom % 10) == 0, ($urandom % 10) == 0,
           ($urandom % 10) == 0, ($urandom % 7) == 0);
    end
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule